// File: doc/BRIEF.md
# Halt mode clock-start sequencer

This block sequences a full-stop power-saving mode for a small processor core. Software writes a 1 to the halt flag. On the next clock edge the sequencer drops both the core clock enable and the oscillator enable, and the whole device stops. Two things bring it out of that state: a wakeup strobe, or the asynchronous reset.

On a wakeup, only the oscillator enable returns at first. The sequencer then counts a fixed warm-up interval before it raises the core clock enable again. The interval is measured in instruction-cycle ticks, and each tick is a fixed number of oscillator clocks.

The warm-up interval depends on the oscillator type:
- With a crystal or resonator, the warm-up is always applied.
- With an RC oscillator, it is applied only when a software-written delay-enable bit is set.

A strap input can disable the halt mode entirely. The core-side pins are plain level and strobe signals; the block carries no data stream.

Top module: `halt_clock_sequencer`

## Requirements
- R1: After reset, core_clk_en = 1, osc_en = 1 and halt_flag = 0.
- R2: Running with halt_dis = 0, a cycle with halt_wr = 1 and halt_wdata = 1 gives halt_flag = 1, core_clk_en = 0 and osc_en = 0 after that clock edge.
- R3: While halted, with no wakeup and no reset, the outputs hold their halted values indefinitely.
- R4: In crystal mode (osc_rc = 0), a wakeup sets osc_en = 1 and halt_flag stays 1. After the clock edge that samples wake = 1, core_clk_en stays 0 for exactly TICK_DIV*START_CNT clocks (2560 with defaults).
- R5: In RC mode (osc_rc = 1) with the delay-enable bit at 1, a wakeup gives the same 2560-clock warm-up.
- R6: In RC mode with the delay-enable bit at 0, core_clk_en returns to 1 on the clock edge that samples wake = 1.
- R7: Reset clears the delay-enable bit, so an RC-mode wakeup after reset has no warm-up. The bit is written by a cycle with cfg_wr = 1, taking its value from cfg_dly_en.
- R8: Taking rst_n low while halted sets core_clk_en = 1 and halt_flag = 0 at once, without waiting for a clock edge.
- R9: While halt_dis = 1, halt writes are ignored: halt_flag stays 0 and core_clk_en stays 1.
- R10: halt_flag returns to 0 in the same cycle that core_clk_en returns to 1.
- R11: Every warm-up lasts the full 2560 clocks, including a second halt/wake round.
- R12: A wake strobe while running, or during warm-up, has no effect: it neither halts the core nor restarts or shortens the warm-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_wr | input | 1 | Halt flag write strobe |
| halt_wdata | input | 1 | Value written to the halt flag |
| cfg_wr | input | 1 | Delay-enable bit write strobe |
| cfg_dly_en | input | 1 | Value written to the delay-enable bit |
| wake | input | 1 | Wakeup event strobe |
| osc_rc | input | 1 | 1 = RC oscillator, 0 = crystal/resonator |
| halt_dis | input | 1 | Strap: 1 blocks entry to halt |
| core_clk_en | output | 1 | Enable for the core clocks |
| osc_en | output | 1 | Enable for the oscillator path |
| halt_flag | output | 1 | Halt flag read value |

## Verification
The three outputs decode the sequencer state directly. A wrong state value therefore shows at the ports on the very next sample: halted with the oscillator on, or running with the flag set.

Faults in the tick divider or the warm-up counter stay hidden until release. They surface only as a release that comes early or late against the expected 2560 clocks, so the bench measures that interval exactly on every wake path. A lost delay-enable bit, or one that is not cleared, shows as a warm-up that is missing or present in RC mode.

// File: rtl/halt_seq_pkg.sv
package halt_seq_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HALT = 2'd1,
    ST_WARM = 2'd2
  } hseq_state_e;
endpackage

// File: rtl/hseq_tick_div.sv
module hseq_tick_div #(
  parameter int TICK_DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic tick
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [DIV_W-1:0] div_q;

  assign tick = en && (div_q == DIV_W'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (clr)    div_q <= '0;
    else if (en)     div_q <= tick ? '0 : div_q + DIV_W'(1);
  end

  // R11
  div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_q < DIV_W'(TICK_DIV));
endmodule

// File: rtl/hseq_start_cnt.sv
module hseq_start_cnt #(
  parameter int START_CNT = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic tick,
  output logic done
);
  localparam int CNT_W = $clog2(START_CNT + 1);

  logic [CNT_W-1:0] cnt_q;

  assign done = tick && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= CNT_W'(START_CNT);
    else if (load)                   cnt_q <= CNT_W'(START_CNT);
    else if (tick && cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
  end

  // R4
  cnt_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (cnt_q != '0));
endmodule

// File: rtl/hseq_ctrl.sv
module hseq_ctrl
  import halt_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic halt_wr,
  input  logic halt_wdata,
  input  logic cfg_wr,
  input  logic cfg_dly_en,
  input  logic wake,
  input  logic osc_rc,
  input  logic halt_dis,
  input  logic done,
  output logic halted,
  output logic warming,
  output logic core_clk_en,
  output logic osc_en,
  output logic halt_flag
);
  hseq_state_e state_q, state_d;
  logic dly_en_q;
  logic halt_req;
  logic need_dly;

  assign halt_req = halt_wr && halt_wdata && !halt_dis;
  assign need_dly = !osc_rc || dly_en_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:  if (halt_req) state_d = ST_HALT;
      ST_HALT: if (wake)     state_d = need_dly ? ST_WARM : ST_RUN;
      ST_WARM: if (done)     state_d = ST_RUN;
      default:               state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_RUN;
      dly_en_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cfg_wr) dly_en_q <= cfg_dly_en;
    end
  end

  assign halted      = (state_q == ST_HALT);
  assign warming     = (state_q == ST_WARM);
  assign core_clk_en = (state_q == ST_RUN);
  assign osc_en      = (state_q != ST_HALT);
  assign halt_flag   = (state_q != ST_RUN);

  // R9
  strap_blocks_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_dis && state_q == ST_RUN) |=> (state_q == ST_RUN));
  // R12
  idle_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && !halt_wr) |=> (state_q == ST_RUN));
  // R3
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HALT && !wake) |=> (state_q == ST_HALT));
  // R6
  rc_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HALT && wake && osc_rc && !dly_en_q) |=> core_clk_en);
  // R10
  release_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WARM && done) |=> (core_clk_en && !halt_flag));
endmodule

// File: rtl/halt_clock_sequencer.sv
module halt_clock_sequencer #(
  parameter int TICK_DIV  = 10,
  parameter int START_CNT = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_wr,
  input  logic halt_wdata,
  input  logic cfg_wr,
  input  logic cfg_dly_en,
  input  logic wake,
  input  logic osc_rc,
  input  logic halt_dis,
  output logic core_clk_en,
  output logic osc_en,
  output logic halt_flag
);
  logic halted;
  logic warming;
  logic tick;
  logic done;

  hseq_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .halt_wr     (halt_wr),
    .halt_wdata  (halt_wdata),
    .cfg_wr      (cfg_wr),
    .cfg_dly_en  (cfg_dly_en),
    .wake        (wake),
    .osc_rc      (osc_rc),
    .halt_dis    (halt_dis),
    .done        (done),
    .halted      (halted),
    .warming     (warming),
    .core_clk_en (core_clk_en),
    .osc_en      (osc_en),
    .halt_flag   (halt_flag)
  );

  hseq_tick_div #(.TICK_DIV(TICK_DIV)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (halted),
    .en    (warming),
    .tick  (tick)
  );

  hseq_start_cnt #(.START_CNT(START_CNT)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (halted),
    .tick  (tick),
    .done  (done)
  );
endmodule

// File: tb/halt_clock_sequencer_test.sv
`timescale 1ns/1ps
module halt_clock_sequencer_test;
  localparam int WARM = 10 * 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_wr = 1'b0, halt_wdata = 1'b0, cfg_wr = 1'b0, cfg_dly_en = 1'b0;
  logic wake = 1'b0, osc_rc = 1'b0, halt_dis = 1'b0;
  logic core_clk_en, osc_en, halt_flag;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  typedef struct { string req; int exp; } item_t;
  item_t exp_q[$];
  int obs_act;
  event obs_ev;

  always #4 clk = ~clk;

  halt_clock_sequencer uut (
    .clk(clk), .rst_n(rst_n), .halt_wr(halt_wr), .halt_wdata(halt_wdata),
    .cfg_wr(cfg_wr), .cfg_dly_en(cfg_dly_en), .wake(wake), .osc_rc(osc_rc),
    .halt_dis(halt_dis), .core_clk_en(core_clk_en), .osc_en(osc_en),
    .halt_flag(halt_flag)
  );

  // monitor: pops the expected item and compares it with the observation
  initial begin
    forever begin
      @(obs_ev);
      if (exp_q.size() != 0) begin
        item_t it;
        it = exp_q.pop_front();
        n_checks++;
        if (obs_act != it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %0d expected %0d", it.req, obs_act, it.exp);
        end
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    item_t it;
    it.req = req;
    it.exp = exp;
    exp_q.push_back(it);
    obs_act = act;
    -> obs_ev;
    #1;
  endtask

  task automatic write_halt(bit v);
    @(negedge clk); halt_wr = 1'b1; halt_wdata = v;
    @(negedge clk); halt_wr = 1'b0; halt_wdata = 1'b0;
  endtask

  task automatic write_cfg(bit v);
    @(negedge clk); cfg_wr = 1'b1; cfg_dly_en = v;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic pulse_wake();
    @(negedge clk); wake = 1'b1;
    @(negedge clk); wake = 1'b0;
  endtask

  // counts samples with core_clk_en low, starting at the current negedge
  task automatic measure(bit inject, output int n);
    n = 0;
    while (core_clk_en == 1'b0 && n < 6000) begin
      n++;
      @(negedge clk);
      if (inject && n == 100) wake = 1'b1;
      if (inject && n == 101) wake = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 core_clk_en", core_clk_en, 1);
    chk("R1 osc_en", osc_en, 1);
    chk("R1 halt_flag", halt_flag, 0);

    pulse_wake();
    chk("R12 wake while running core_clk_en", core_clk_en, 1);
    chk("R12 wake while running halt_flag", halt_flag, 0);

    halt_dis = 1'b1;
    write_halt(1'b1);
    chk("R9 strap halt_flag", halt_flag, 0);
    chk("R9 strap core_clk_en", core_clk_en, 1);
    halt_dis = 1'b0;

    write_halt(1'b1);
    chk("R2 halt_flag", halt_flag, 1);
    chk("R2 core_clk_en", core_clk_en, 0);
    chk("R2 osc_en", osc_en, 0);

    repeat (50) @(negedge clk);
    chk("R3 hold halt_flag", halt_flag, 1);
    chk("R3 hold osc_en", osc_en, 0);

    osc_rc = 1'b0;
    pulse_wake();
    chk("R4 osc_en on wake", osc_en, 1);
    chk("R4 halt_flag during warm-up", halt_flag, 1);
    measure(1'b1, n);
    chk("R4 R12 crystal warm-up clocks", n, WARM);
    chk("R10 halt_flag at release", halt_flag, 0);

    write_halt(1'b1);
    pulse_wake();
    measure(1'b0, n);
    chk("R11 second warm-up clocks", n, WARM);

    write_cfg(1'b1);
    osc_rc = 1'b1;
    write_halt(1'b1);
    pulse_wake();
    measure(1'b0, n);
    chk("R5 RC with delay clocks", n, WARM);

    write_cfg(1'b0);
    write_halt(1'b1);
    pulse_wake();
    measure(1'b0, n);
    chk("R6 RC no delay clocks", n, 0);
    chk("R6 halt_flag", halt_flag, 0);

    write_cfg(1'b1);
    write_halt(1'b1);
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk("R8 async reset core_clk_en", core_clk_en, 1);
    chk("R8 async reset halt_flag", halt_flag, 0);
    @(negedge clk); rst_n = 1'b1;

    write_halt(1'b1);
    pulse_wake();
    measure(1'b0, n);
    chk("R7 delay bit cleared by reset", n, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule